// File: doc/BRIEF.md
# RTC Update Cycle and Interrupt Controller

This block runs the once-per-second update of a real-time clock and owns the clock's control and status registers. It keeps a running time of day in binary, in seconds, minutes and hours. The visible copies of that time sit in byte registers that software reads and writes over a simple indexed bus. A one-second tick opens an update. If the divider field of the control register shows normal running, the running time advances by one second and the update-in-progress flag is raised. A later delay strobe closes the update. It copies the new time into the visible registers, checks the alarm, posts the update-ended flag and drops update-in-progress.

Software controls the block through two registers. The configuration register selects binary or BCD and a 12 or 24 hour format, enables the alarm and update-ended interrupts, and has a freeze bit that stops the visible time from changing while software loads new values. The status register collects interrupt flags. Reading it returns the flags, clears them and releases the interrupt line. Date arithmetic is not part of this block.

Top module: `rtc_update_ctrl`

## Requirements
- R1: After reset, index 10 (register A) reads 0x26, index 11 (register B) reads 0x02, index 12 (register C) reads 0x00, index 13 (register D) reads 0x80, and irq is low.
- R2: A secTick pulse starts an update only while register A bits 6:4 equal 010b. The update advances the running time by one second, with seconds wrapping after 59, minutes after 59 and hours after 23. It sets UIP (register A bit 7) unless SET (register B bit 7) is 1. With any other divider value the tick is skipped: no advance, no UIP, and no update end follows.
- R3: The first delayStb after a started update ends it. If SET is 0, it copies the running time into index 0 (seconds), index 2 (minutes) and index 4 (hours). In all cases it clears UIP. While SET is 1 the visible time keeps its value.
- R4: A bus write to register A stores bits 6:0. Bit 7 (UIP) keeps the value the update sequence gives it.
- R5: A write to register B with bit 7 set clears UIP and stores bit 4 (UIE) as 0.
- R6: While SET is 0, a write to a time register also loads the running time from the written byte. A write to register B that changes SET from 1 to 0 loads the running time from all three visible time registers.
- R7: Register B bit 2 = 1 selects binary values and 0 selects BCD. Bit 1 = 1 selects 24 hour format. With bit 1 = 0 the hours byte holds hour mod 12, and bit 7 is set when the hour is 12 or more. The same encoding is used when time bytes are decoded on writes.
- R8: When UIE (register B bit 4) is 1, the end of each update ORs 0x90 into register C.
- R9: When AIE (register B bit 5) is 1, the end of an update ORs 0xA0 into register C if each alarm byte (index 1 seconds, index 3 minutes, index 5 hours) matches the matching field of the new time. The field is in the current encoding, and minutes are compared with minutes. An alarm byte whose bits 7:6 are 11b matches any value.
- R10: irq follows register C bit 7. A bus read of register C returns its value, then clears it to 0x00, which drops irq.
- R11: Bus writes to register C and register D have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for one cycle |
| busRd | input | 1 | Read strobe for one cycle |
| busIdx | input | IDX_W | Register index |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, registered on the read strobe |
| secTick | input | 1 | One-second tick pulse |
| delayStb | input | 1 | Strobe that ends an update in progress |
| irq | output | 1 | Interrupt request, high while register C bit 7 is set |

## Verification
A wrong running time stays hidden until the next update end copies it out. That happens about one delayStb after the next tick, and only when SET is low. The bench therefore reads the time registers after every update, including a wrap of all three fields and a release from freeze. A wrong UIP or interrupt flag shows in the register A or C byte, or on irq, on the first read after the strobe that should have changed it. The bench reads inside and after each update, with the freeze bit set and clear, and with matching, wildcard and missing alarm fields.

// File: rtl/rtc_uc_pkg.sv
package rtc_uc_pkg;

  localparam int DATA_W = 8;
  localparam int TIME_W = 8;

  localparam logic [TIME_W-1:0] SEC_LAST = 8'd59;
  localparam logic [TIME_W-1:0] MIN_LAST = 8'd59;
  localparam logic [TIME_W-1:0] HRS_LAST = 8'd23;
  localparam logic [TIME_W-1:0] HALF_DAY = 8'd12;

  // register A
  localparam int UIP_BIT = 7;
  localparam int DIV_HI  = 6;
  localparam int DIV_LO  = 4;
  localparam logic [DIV_HI-DIV_LO:0] DIV_RUN = 3'b010;
  // register B
  localparam int SET_BIT = 7;
  localparam int AIE_BIT = 5;
  localparam int UIE_BIT = 4;
  localparam int BIN_BIT = 2;
  localparam int H24_BIT = 1;
  // register C
  localparam int IRQF_BIT = 7;
  localparam int AF_BIT   = 5;
  localparam int UF_BIT   = 4;
  localparam logic [1:0] WILD = 2'b11;

  typedef struct packed {
    logic advance;
    logic markUip;
    logic finish;
  } updStrobe_t;

  function automatic logic [DATA_W-1:0] encVal(input logic [TIME_W-1:0] v, input logic bin);
    logic [TIME_W-1:0] tens, ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return bin ? v : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [TIME_W-1:0] decVal(input logic [DATA_W-1:0] b, input logic bin);
    logic [TIME_W-1:0] hi, lo;
    hi = {4'd0, b[7:4]};
    lo = {4'd0, b[3:0]};
    return bin ? b : (hi * 8'd10 + lo);
  endfunction

  function automatic logic [DATA_W-1:0] encHour(input logic [TIME_W-1:0] h, input logic bin,
                                                input logic h24);
    logic [DATA_W-1:0] r;
    if (h24) begin
      r = encVal(h, bin);
    end else begin
      r = encVal(h % HALF_DAY, bin);
      r[7] = (h >= HALF_DAY);
    end
    return r;
  endfunction

  function automatic logic [TIME_W-1:0] decHour(input logic [DATA_W-1:0] b, input logic bin,
                                                input logic h24);
    logic [TIME_W-1:0] r;
    if (h24) begin
      r = decVal(b, bin);
    end else begin
      r = decVal({1'b0, b[6:0]}, bin);
      if (b[7]) r = r + HALF_DAY;
    end
    return r;
  endfunction

  function automatic logic fieldHit(input logic [DATA_W-1:0] alm, input logic [DATA_W-1:0] cur);
    return (alm[7:6] == WILD) || (alm == cur);
  endfunction

endpackage

// File: rtl/rtc_uc_ctrl.sv
module rtc_uc_ctrl
  import rtc_uc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       delayStb,
  input  logic       dividerRun,
  input  logic       setMode,
  output updStrobe_t strobe
);

  logic pend;

  always_comb begin
    strobe.advance = secTick & ~pend & dividerRun;
    strobe.markUip = secTick & ~pend & dividerRun & ~setMode;
    strobe.finish  = delayStb & pend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= 1'b0;
    end else if (strobe.advance) begin
      pend <= 1'b1;
    end else if (strobe.finish) begin
      pend <= 1'b0;
    end
  end

  // R2
  start_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pend) |-> $past(secTick && dividerRun));

  // R2
  skip_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !dividerRun && !pend) |=> !pend);

  // R3
  end_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (delayStb && pend) |=> !pend);

endmodule

// File: rtl/rtc_uc_dpath.sv
module rtc_uc_dpath
  import rtc_uc_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter logic [IDX_W-1:0] IDX_SEC   = 4'd0,
  parameter logic [IDX_W-1:0] IDX_ASEC  = 4'd1,
  parameter logic [IDX_W-1:0] IDX_MIN   = 4'd2,
  parameter logic [IDX_W-1:0] IDX_AMIN  = 4'd3,
  parameter logic [IDX_W-1:0] IDX_HRS   = 4'd4,
  parameter logic [IDX_W-1:0] IDX_AHRS  = 4'd5,
  parameter logic [IDX_W-1:0] IDX_CTLA  = 4'd10,
  parameter logic [IDX_W-1:0] IDX_CTLB  = 4'd11,
  parameter logic [IDX_W-1:0] IDX_STAT  = 4'd12,
  parameter logic [IDX_W-1:0] IDX_VALID = 4'd13,
  parameter logic [DATA_W-1:0] A_RST = 8'h26,
  parameter logic [DATA_W-1:0] B_RST = 8'h02,
  parameter logic [DATA_W-1:0] D_VAL = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [IDX_W-1:0]  busIdx,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  updStrobe_t        strobe,
  output logic              dividerRun,
  output logic              setMode,
  output logic              irq
);

  logic [DATA_W-1:0] secVis, minVis, hrsVis;
  logic [DATA_W-1:0] almSec, almMin, almHrs;
  logic [DATA_W-1:0] regA, regB, regC, rdData;
  logic [DATA_W-1:0] aNext, bNext, cNext, raiseC, rdMux;
  logic [DATA_W-1:0] curSec, curMin, curHrs;
  logic [TIME_W-1:0] tSec, tMin, tHrs;
  logic [TIME_W-1:0] nSec, nMin, nHrs;
  logic binMode, h24Mode, almHit, uipNext;
  logic wrSec, wrMin, wrHrs, wrA, wrB, rdC, setWrite, setFall;

  assign binMode    = regB[BIN_BIT];
  assign h24Mode    = regB[H24_BIT];
  assign setMode    = regB[SET_BIT];
  assign dividerRun = (regA[DIV_HI:DIV_LO] == DIV_RUN);
  assign irq        = regC[IRQF_BIT];
  assign busRdata   = rdData;

  assign wrSec    = busWr && (busIdx == IDX_SEC);
  assign wrMin    = busWr && (busIdx == IDX_MIN);
  assign wrHrs    = busWr && (busIdx == IDX_HRS);
  assign wrA      = busWr && (busIdx == IDX_CTLA);
  assign wrB      = busWr && (busIdx == IDX_CTLB);
  assign rdC      = busRd && (busIdx == IDX_STAT);
  assign setWrite = wrB && busWdata[SET_BIT];
  assign setFall  = wrB && !busWdata[SET_BIT] && regB[SET_BIT];

  // running time, encoded the way the visible registers hold it
  assign curSec = encVal(tSec, binMode);
  assign curMin = encVal(tMin, binMode);
  assign curHrs = encHour(tHrs, binMode, h24Mode);

  // one-second advance of the running time
  always_comb begin
    nSec = tSec + 8'd1;
    nMin = tMin;
    nHrs = tHrs;
    if (tSec >= SEC_LAST) begin
      nSec = '0;
      if (tMin >= MIN_LAST) begin
        nMin = '0;
        nHrs = (tHrs >= HRS_LAST) ? '0 : (tHrs + 8'd1);
      end else begin
        nMin = tMin + 8'd1;
      end
    end
  end

  assign almHit = fieldHit(almSec, curSec) && fieldHit(almMin, curMin) &&
                  fieldHit(almHrs, curHrs);

  always_comb begin
    raiseC = '0;
    if (strobe.finish) begin
      if (regB[AIE_BIT] && almHit) begin
        raiseC[IRQF_BIT] = 1'b1;
        raiseC[AF_BIT]   = 1'b1;
      end
      if (regB[UIE_BIT]) begin
        raiseC[IRQF_BIT] = 1'b1;
        raiseC[UF_BIT]   = 1'b1;
      end
    end
  end

  always_comb begin
    uipNext = regA[UIP_BIT];
    if (strobe.markUip) uipNext = 1'b1;
    if (strobe.finish)  uipNext = 1'b0;
    if (setWrite)       uipNext = 1'b0;
    aNext = wrA ? {uipNext, busWdata[6:0]} : {uipNext, regA[6:0]};
    bNext = regB;
    if (wrB) begin
      bNext = busWdata;
      if (busWdata[SET_BIT]) bNext[UIE_BIT] = 1'b0;
    end
    cNext = (rdC ? '0 : regC) | raiseC;
  end

  always_comb begin
    rdMux = '0;
    unique case (busIdx)
      IDX_SEC:   rdMux = secVis;
      IDX_ASEC:  rdMux = almSec;
      IDX_MIN:   rdMux = minVis;
      IDX_AMIN:  rdMux = almMin;
      IDX_HRS:   rdMux = hrsVis;
      IDX_AHRS:  rdMux = almHrs;
      IDX_CTLA:  rdMux = regA;
      IDX_CTLB:  rdMux = regB;
      IDX_STAT:  rdMux = regC;
      IDX_VALID: rdMux = D_VAL;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA   <= A_RST;
      regB   <= B_RST;
      regC   <= '0;
      secVis <= '0;
      minVis <= '0;
      hrsVis <= '0;
      almSec <= '0;
      almMin <= '0;
      almHrs <= '0;
      tSec   <= '0;
      tMin   <= '0;
      tHrs   <= '0;
      rdData <= '0;
    end else begin
      regA <= aNext;
      regB <= bNext;
      regC <= cNext;
      if (strobe.advance) begin
        tSec <= nSec;
        tMin <= nMin;
        tHrs <= nHrs;
      end
      if (strobe.finish && !setMode) begin
        secVis <= curSec;
        minVis <= curMin;
        hrsVis <= curHrs;
      end
      if (wrSec) begin
        secVis <= busWdata;
        if (!setMode) tSec <= decVal(busWdata, binMode);
      end
      if (wrMin) begin
        minVis <= busWdata;
        if (!setMode) tMin <= decVal(busWdata, binMode);
      end
      if (wrHrs) begin
        hrsVis <= busWdata;
        if (!setMode) tHrs <= decHour(busWdata, binMode, h24Mode);
      end
      if (busWr && (busIdx == IDX_ASEC)) almSec <= busWdata;
      if (busWr && (busIdx == IDX_AMIN)) almMin <= busWdata;
      if (busWr && (busIdx == IDX_AHRS)) almHrs <= busWdata;
      if (setFall) begin
        tSec <= decVal(secVis, binMode);
        tMin <= decVal(minVis, binMode);
        tHrs <= decHour(hrsVis, binMode, h24Mode);
      end
      if (busRd) rdData <= rdMux;
    end
  end

  // R5
  uie_off_in_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    regB[SET_BIT] |-> !regB[UIE_BIT]);

  // R5
  uip_off_in_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    regB[SET_BIT] |-> !regA[UIP_BIT]);

  // R3
  uip_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(regA[UIP_BIT]) |-> $past(strobe.finish || setWrite));

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdC && !strobe.finish) |=> (regC == '0));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(strobe.finish));

  // R11
  stat_low_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regC[3:0] == 4'd0);

endmodule

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl
  import rtc_uc_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter logic [DATA_W-1:0] A_RST = 8'h26,
  parameter logic [DATA_W-1:0] B_RST = 8'h02,
  parameter logic [DATA_W-1:0] D_VAL = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [IDX_W-1:0]  busIdx,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              secTick,
  input  logic              delayStb,
  output logic              irq
);

  updStrobe_t strobe;
  logic dividerRun, setMode;

  rtc_uc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .secTick   (secTick),
    .delayStb  (delayStb),
    .dividerRun(dividerRun),
    .setMode   (setMode),
    .strobe    (strobe)
  );

  rtc_uc_dpath #(
    .IDX_W    (IDX_W),
    .IDX_SEC  (IDX_W'(0)),
    .IDX_ASEC (IDX_W'(1)),
    .IDX_MIN  (IDX_W'(2)),
    .IDX_AMIN (IDX_W'(3)),
    .IDX_HRS  (IDX_W'(4)),
    .IDX_AHRS (IDX_W'(5)),
    .IDX_CTLA (IDX_W'(10)),
    .IDX_CTLB (IDX_W'(11)),
    .IDX_STAT (IDX_W'(12)),
    .IDX_VALID(IDX_W'(13)),
    .A_RST    (A_RST),
    .B_RST    (B_RST),
    .D_VAL    (D_VAL)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busRd     (busRd),
    .busIdx    (busIdx),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .strobe    (strobe),
    .dividerRun(dividerRun),
    .setMode   (setMode),
    .irq       (irq)
  );

endmodule

// File: tb/rtc_update_ctrl_tb.sv
`timescale 1ns/1ps
module rtc_update_ctrl_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0, secTick = 1'b0, delayStb = 1'b0;
  logic [3:0] busIdx = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_update_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busIdx(busIdx),
    .busWdata(busWdata), .busRdata(busRdata), .secTick(secTick),
    .delayStb(delayStb), .irq(irq)
  );

  localparam logic [3:0] I_SEC = 4'd0, I_ASEC = 4'd1, I_MIN = 4'd2, I_AMIN = 4'd3;
  localparam logic [3:0] I_HRS = 4'd4, I_AHRS = 4'd5, I_A = 4'd10, I_B = 4'd11;
  localparam logic [3:0] I_C = 4'd12, I_D = 4'd13;

  function automatic logic [7:0] mEnc(input int v, input bit bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] mEncH(input int h, input bit bin, input bit h24);
    if (h24) return mEnc(h, bin);
    return mEnc(h % 12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busIdx = idx; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] d);
    @(negedge clk);
    busRd = 1'b1; busIdx = idx;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic rdChk(input string req, input logic [3:0] idx, input logic [7:0] exp);
    logic [7:0] v;
    rd(idx, v);
    chk(req, v, exp);
  endtask

  task automatic tick();
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
  endtask

  task automatic fin();
    @(negedge clk); delayStb = 1'b1;
    @(negedge clk); delayStb = 1'b0;
  endtask

  task automatic update();
    tick(); repeat (3) @(negedge clk); fin();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int s, m, h;
    bit bin, h24;
    int seedDummy;
    seedDummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rdChk("R1 regA", I_A, 8'h26);
    rdChk("R1 regB", I_B, 8'h02);
    rdChk("R1 regC", I_C, 8'h00);
    rdChk("R1 regD", I_D, 8'h80);

    // R6 R2 R3: load 23:59:58 BCD, run two updates through a full wrap
    wr(I_SEC, 8'h58); wr(I_MIN, 8'h59); wr(I_HRS, 8'h23);
    tick();
    rdChk("R2 UIP set during update", I_A, 8'hA6);
    fin();
    rdChk("R3 UIP cleared at end", I_A, 8'h26);
    rdChk("R3 sec after update", I_SEC, 8'h59);
    rdChk("R3 min after update", I_MIN, 8'h59);
    rdChk("R3 hrs after update", I_HRS, 8'h23);
    update();
    rdChk("R2 sec wrap", I_SEC, 8'h00);
    rdChk("R2 min wrap", I_MIN, 8'h00);
    rdChk("R2 hrs wrap", I_HRS, 8'h00);

    // R4 UIP read only
    wr(I_A, 8'hA6);
    rdChk("R4 UIP not writable high", I_A, 8'h26);
    tick();
    wr(I_A, 8'h26);
    rdChk("R4 UIP kept on write", I_A, 8'hA6);
    fin();
    rdChk("R4 sec", I_SEC, 8'h01);

    // R2 divider not running: tick skipped
    wr(I_A, 8'h06);
    tick();
    rdChk("R2 no UIP when divider stopped", I_A, 8'h06);
    fin();
    rdChk("R2 no advance when divider stopped", I_SEC, 8'h01);
    wr(I_A, 8'h26);

    // R5 SET clears UIP and UIE, R3 frozen visible time
    tick();
    wr(I_B, 8'h92);
    rdChk("R5 SET clears UIP", I_A, 8'h26);
    rdChk("R5 UIE forced low", I_B, 8'h82);
    fin();
    rdChk("R3 frozen sec", I_SEC, 8'h01);
    rdChk("R5 no update-ended flag", I_C, 8'h00);
    wr(I_SEC, 8'h30);
    tick();
    rdChk("R2 no UIP while SET", I_A, 8'h26);
    fin();
    rdChk("R3 frozen after write", I_SEC, 8'h30);
    // R6 reload on SET release
    wr(I_B, 8'h02);
    update();
    rdChk("R6 reload on SET release", I_SEC, 8'h31);
    rdChk("R6 min after reload", I_MIN, 8'h00);

    // R8 update-ended interrupt, R10 read to clear
    wr(I_B, 8'h12);
    update();
    chk("R10 irq raised", {7'd0, irq}, 8'h01);
    rdChk("R8 update-ended flags", I_C, 8'h90);
    chk("R10 irq dropped after read", {7'd0, irq}, 8'h00);
    rdChk("R10 regC cleared", I_C, 8'h00);

    // R9 alarm: exact seconds, wildcard minutes and hours (time becomes 00:00:33)
    wr(I_B, 8'h22);
    wr(I_ASEC, 8'h33); wr(I_AMIN, 8'hC0); wr(I_AHRS, 8'hC0);
    update();
    chk("R9 irq on alarm", {7'd0, irq}, 8'h01);
    rdChk("R9 alarm flags", I_C, 8'hA0);
    // R9 minute mismatch (00:00:34)
    wr(I_ASEC, 8'hC0); wr(I_AMIN, 8'h05);
    update();
    rdChk("R9 minute mismatch", I_C, 8'h00);
    chk("R9 no irq on mismatch", {7'd0, irq}, 8'h00);
    // R9 R8 both sources, minutes compared with minutes (00:00:35)
    wr(I_AMIN, 8'h00); wr(I_B, 8'h32);
    update();
    rdChk("R9 alarm and update flags", I_C, 8'hB0);

    // R7 binary, 12 hour
    wr(I_B, 8'h04);
    wr(I_HRS, 8'h8B); wr(I_MIN, 8'h3B); wr(I_SEC, 8'h3B);
    update();
    rdChk("R7 12h midnight hrs", I_HRS, 8'h00);
    rdChk("R7 binary min", I_MIN, 8'h00);
    rdChk("R7 binary sec", I_SEC, 8'h00);
    wr(I_HRS, 8'h0B); wr(I_MIN, 8'h3B); wr(I_SEC, 8'h3B);
    update();
    rdChk("R7 12h noon pm bit", I_HRS, 8'h80);

    // R11 writes to C and D ignored
    wr(I_C, 8'hFF);
    rdChk("R11 regC write ignored", I_C, 8'h00);
    chk("R11 no irq from write", {7'd0, irq}, 8'h00);
    wr(I_D, 8'h00);
    rdChk("R11 regD write ignored", I_D, 8'h80);

    // R7 R2 random times in random encodings
    for (int i = 0; i < 24; i++) begin
      bin = 1'($urandom % 2);
      h24 = 1'($urandom % 2);
      s = (i % 3 == 0) ? 59 : int'($urandom % 60);
      m = (i % 6 == 0) ? 59 : int'($urandom % 60);
      h = (i % 12 == 0) ? 23 : int'($urandom % 24);
      wr(I_B, {5'd0, bin, h24, 1'b0});
      wr(I_SEC, mEnc(s, bin)); wr(I_MIN, mEnc(m, bin)); wr(I_HRS, mEncH(h, bin, h24));
      update();
      s++;
      if (s == 60) begin
        s = 0; m++;
        if (m == 60) begin
          m = 0; h = (h == 23) ? 0 : h + 1;
        end
      end
      rdChk("R7 random sec", I_SEC, mEnc(s, bin));
      rdChk("R7 random min", I_MIN, mEnc(m, bin));
      rdChk("R7 random hrs", I_HRS, mEncH(h, bin, h24));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule